// File: doc/BRIEF.md
# Masked Pattern Search Comparator

This block sits beside the data path of a DMA channel that runs search or transfer-and-search operations. Each time the channel reads a data word it raises a one-cycle strobe, and the comparator checks that word against a programmed pattern. A companion mask selects bits that are "don't care": a mask bit of one makes that bit position compare as equal whatever the data and pattern hold.

A two-bit match-control field chooses how a hit is used. Two codes give no termination. The other two end the operation on a hit, judged on the whole word or on the low byte only. A byte/word operation flag narrows the compare to the low byte whenever the channel moves bytes, because the upper byte then carries no data. The block reports the compare result of the last strobed word as a flag. It also raises a one-cycle terminate request that the channel sequencer turns into a match-condition stop. In a search operation that stop ends the scan. In transfer-and-search it ends the transfer after the matching word.

Top module: `srch_match_cmp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `match_o` and `term_o` are both 0.
- R2: A bit set to 1 in `mask_i` makes that bit position count as equal, whatever the values of `data_i` and `pattern_i` at that bit.
- R3: With `match_ctl_i` = 2'b10 (word match) and `byte_op_i` = 0, a word hits only when every bit 15..0 whose mask bit is 0 equals the pattern bit.
- R4: With `match_ctl_i` = 2'b11 (byte match), only bits 7..0 of data, pattern and mask take part in the compare. Bits 15..8 have no effect on `match_o` or `term_o`.
- R5: With `byte_op_i` = 1, the compare uses bits 7..0 only, whatever the value of `match_ctl_i`.
- R6: On the clock edge that samples `data_vld_i` = 1, `match_o` takes the compare result of that word. Without a strobe, `match_o` holds its value.
- R7: When a strobed word hits and `match_ctl_i` is 2'b10 or 2'b11, `term_o` is 1 for the single cycle after that strobe. It is 0 in the cycle after that, unless another hitting strobe follows.
- R8: With `match_ctl_i` = 2'b00 (no termination) or 2'b01 (reserved, treated as no termination), `term_o` stays 0. `match_o` still shows the compare result.
- R9: In a cycle that follows no strobe, `term_o` is 0 even when data and pattern are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| data_vld_i | input | 1 | One-cycle strobe: `data_i` holds a word read by the channel |
| data_i | input | DATA_W (16) | Data word under test |
| pattern_i | input | DATA_W (16) | Pattern to compare against |
| mask_i | input | DATA_W (16) | Don't-care mask; 1 = bit always equal |
| match_ctl_i | input | 2 | 00 none, 01 reserved (none), 10 word match, 11 byte match |
| byte_op_i | input | 1 | 1 = the channel moves bytes; compare low byte only |
| match_o | output | 1 | Compare result of the last strobed word |
| term_o | output | 1 | One-cycle match-condition termination request |

## Verification
On every cycle the assertions check these properties: a terminate request follows only a strobe; it comes only with a set match flag; it needs a terminating match-control code; the flag holds between strobes; and an exact unmasked word compare always leads to a set flag. The bench's scenarios show the behaviour that needs chosen data. These cases are: mask bits hiding differing data, the upper byte being ignored in byte match and in byte operations, the reserved code acting as no termination, and back-to-back strobes giving one request each.

// File: rtl/srch_cmp_pkg.sv
package srch_cmp_pkg;

    typedef enum logic [1:0] {
        MC_NONE = 2'b00,
        MC_RSVD = 2'b01,
        MC_WORD = 2'b10,
        MC_BYTE = 2'b11
    } match_ctl_e;

    typedef struct packed {
        logic match;
        logic term;
    } cmp_state_t;

endpackage

// File: rtl/srch_mask_eq.sv
module srch_mask_eq #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] pattern_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [LANES-1:0]  lane_eq_o
);

    // One comparator per lane; a masked bit always counts as equal.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bit_ok;
        assign bit_ok = ~(data_i[g*LANE_W +: LANE_W] ^ pattern_i[g*LANE_W +: LANE_W])
                        | mask_i[g*LANE_W +: LANE_W];
        assign lane_eq_o[g] = &bit_ok;
    end

endmodule

// File: rtl/srch_term_dec.sv
module srch_term_dec
    import srch_cmp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] lane_eq_i,
    input  logic [1:0]       match_ctl_i,
    input  logic             byte_op_i,
    output logic             hit_o,
    output logic             stop_o
);

    match_ctl_e ctl;
    logic       use_low;

    always_comb begin
        ctl     = match_ctl_e'(match_ctl_i);
        use_low = byte_op_i || (ctl == MC_BYTE);
        hit_o   = use_low ? lane_eq_i[0] : (&lane_eq_i);
        stop_o  = hit_o && ((ctl == MC_WORD) || (ctl == MC_BYTE));
    end

endmodule

// File: rtl/srch_match_cmp.sv
module srch_match_cmp
    import srch_cmp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              data_vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] pattern_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [1:0]        match_ctl_i,
    input  logic              byte_op_i,
    output logic              match_o,
    output logic              term_o
);

    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_eq;
    logic             hit;
    logic             stop;
    cmp_state_t       st_d, st_q;

    srch_mask_eq #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) eq_i (
        .data_i    (data_i),
        .pattern_i (pattern_i),
        .mask_i    (mask_i),
        .lane_eq_o (lane_eq)
    );

    srch_term_dec #(
        .LANES (LANES)
    ) dec_i (
        .lane_eq_i   (lane_eq),
        .match_ctl_i (match_ctl_i),
        .byte_op_i   (byte_op_i),
        .hit_o       (hit),
        .stop_o      (stop)
    );

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        if (data_vld_i) begin
            st_d.match = hit;
            st_d.term  = stop;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;
    assign term_o  = st_q.term;

endmodule

// File: rtl/srch_match_cmp_chk.sv
module srch_match_cmp_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              data_vld_i,
    input logic [DATA_W-1:0] data_i,
    input logic [DATA_W-1:0] pattern_i,
    input logic [DATA_W-1:0] mask_i,
    input logic [1:0]        match_ctl_i,
    input logic              byte_op_i,
    input logic              match_o,
    input logic              term_o
);

    AST_TERM_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !data_vld_i |=> !term_o); // R9

    AST_TERM_WITH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |-> match_o); // R7

    AST_NONE_NO_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !match_ctl_i[1] |=> !term_o); // R8

    AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !data_vld_i |=> $stable(match_o)); // R6

    AST_WORD_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_vld_i && !byte_op_i && (((data_i ^ pattern_i) & ~mask_i) == '0))
        |=> match_o); // R3

    AST_WORD_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_vld_i && (match_ctl_i == 2'b10) && (data_i == pattern_i)) |=> term_o); // R7

endmodule

bind srch_match_cmp srch_match_cmp_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_vld_i  (data_vld_i),
    .data_i      (data_i),
    .pattern_i   (pattern_i),
    .mask_i      (mask_i),
    .match_ctl_i (match_ctl_i),
    .byte_op_i   (byte_op_i),
    .match_o     (match_o),
    .term_o      (term_o)
);

// File: tb/srch_match_cmp_tb_top.sv
`timescale 1ns/1ps
module srch_match_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [15:0] data = '0;
    logic [15:0] pat = '0;
    logic [15:0] mask = '0;
    logic [1:0]  ctl = 2'b00;
    logic        bop = 1'b0;
    logic        match;
    logic        term;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    srch_match_cmp dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .data_vld_i  (vld),
        .data_i      (data),
        .pattern_i   (pat),
        .mask_i      (mask),
        .match_ctl_i (ctl),
        .byte_op_i   (bop),
        .match_o     (match),
        .term_o      (term)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
            $finish;
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Reference result taken from the requirements.
    function automatic logic ref_hit(input logic [15:0] d, input logic [15:0] p,
                                     input logic [15:0] m, input logic [1:0] c,
                                     input logic b);
        logic lo, wd;
        lo = (((d[7:0] ^ p[7:0]) & ~m[7:0]) == 8'h00);
        wd = (((d ^ p) & ~m) == 16'h0000);
        return (b || c == 2'b11) ? lo : wd;
    endfunction

    // Strobe one word and check both outputs in the following cycle.
    task automatic strobe(input logic [15:0] d, input logic [15:0] p, input logic [15:0] m,
                          input logic [1:0] c, input logic b, input string req);
        logic h;
        h = ref_hit(d, p, m, c, b);
        @(negedge clk);
        data = d; pat = p; mask = m; ctl = c; bop = b; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        check(match, h, req);
        check(term, h && c[1], req);
        @(negedge clk);
        check(term, 1'b0, {req, " term one cycle"});
    endtask

    task automatic t_reset;
        data = 16'hAAAA; pat = 16'hAAAA; ctl = 2'b10; vld = 1'b1;
        repeat (3) @(negedge clk);
        check(match, 1'b0, "R1 match in reset");
        check(term, 1'b0, "R1 term in reset");
        rst_n = 1'b1; vld = 1'b0;
        @(negedge clk);
        check(match, 1'b0, "R1 match after reset");
        check(term, 1'b0, "R1 term after reset");
    endtask

    task automatic t_word;
        strobe(16'h1234, 16'h1234, 16'h0000, 2'b10, 1'b0, "R3 exact word");
        strobe(16'h1234, 16'h1235, 16'h0000, 2'b10, 1'b0, "R3 low bit differs");
        strobe(16'h9234, 16'h1234, 16'h0000, 2'b10, 1'b0, "R3 high bit differs");
    endtask

    task automatic t_mask;
        strobe(16'hF0F0, 16'h0F0F, 16'hFFFF, 2'b10, 1'b0, "R2 full mask");
        strobe(16'h8001, 16'h0000, 16'h8001, 2'b10, 1'b0, "R2 masked edge bits");
        strobe(16'h8003, 16'h0000, 16'h8001, 2'b10, 1'b0, "R2 unmasked bit differs");
    endtask

    task automatic t_byte;
        strobe(16'hAB5A, 16'h125A, 16'h0000, 2'b11, 1'b0, "R4 upper byte ignored");
        strobe(16'h005B, 16'h005A, 16'h0000, 2'b11, 1'b0, "R4 low byte differs");
        strobe(16'h005B, 16'h005A, 16'h0001, 2'b11, 1'b0, "R4 low mask applies");
        strobe(16'h3377, 16'hCC77, 16'h0000, 2'b10, 1'b1, "R5 byte op word ctl");
        strobe(16'h3376, 16'hCC77, 16'h0000, 2'b00, 1'b1, "R5 byte op none ctl");
    endtask

    task automatic t_none;
        strobe(16'h4242, 16'h4242, 16'h0000, 2'b00, 1'b0, "R8 none ctl hit");
        strobe(16'h4242, 16'h4242, 16'h0000, 2'b01, 1'b0, "R8 reserved ctl hit");
        strobe(16'h4342, 16'h4242, 16'h0000, 2'b01, 1'b0, "R8 reserved ctl miss");
    endtask

    task automatic t_hold;
        strobe(16'h0101, 16'h0101, 16'h0000, 2'b10, 1'b0, "R6 set flag");
        @(negedge clk);
        data = 16'hFFFF; pat = 16'h0000;
        repeat (3) @(negedge clk);
        check(match, 1'b1, "R6 flag holds without strobe");
        data = 16'h5555; pat = 16'h5555; ctl = 2'b10;
        repeat (2) @(negedge clk);
        check(term, 1'b0, "R9 no strobe no term");
        check(match, 1'b1, "R6 flag still held");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        data = 16'h7777; pat = 16'h7777; mask = '0; ctl = 2'b11; bop = 1'b0; vld = 1'b1;
        @(negedge clk);
        check(term, 1'b1, "R7 first strobe term");
        data = 16'h7778;
        @(negedge clk);
        vld = 1'b0;
        check(term, 1'b0, "R7 missed second strobe");
        check(match, 1'b0, "R6 flag follows second strobe");
        @(negedge clk);
        check(term, 1'b0, "R7 term idle");
    endtask

    initial begin
        t_reset();
        t_word();
        t_mask();
        t_byte();
        t_none();
        t_hold();
        t_back_to_back();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule